// File: doc/BRIEF.md
# Receive FIFO Host Request Generator

This block decides when the host should be asked to drain a receive FIFO. It watches the FIFO's byte count, the running byte count of the frame being received, frame start and end strobes, and a handful of configuration inputs. From these it drives one registered request line.

The request obeys a selectable FIFO threshold. A frame must first deliver a full minimum-length block of bytes before the threshold applies. Short, pad-stripped and low-latency frames are exceptions to that hold-off. When the receiver is turned off, the request is held low. The frame already in flight still finishes into the FIFO. Frames that arrive while the receiver is off, and would otherwise have reached the host, are tallied in a saturating missed-frame counter.

All pins are plain level or strobe signals. No data passes through the block, so no valid/ready handshake exists and no back-pressure applies. The host may read valid FIFO data while the request is low. The block does nothing to prevent FIFO overflow while the receiver is disabled.

Top module: `rxreq_gen`

## Requirements
- R1: The threshold register is written by `cfg_wr_i` with `cfg_thr_i`: 2'b00 selects MIN_BYTES/4 (16), 2'b01 selects MIN_BYTES/2 (32), and 2'b10 or 2'b11 selects MIN_BYTES (64). Reset selects 64.
- R2: With the receiver enabled, the request is high two clock edges after the FIFO count reaches at least 64, whatever the frame state.
- R3: Once the current frame has received at least 64 bytes, the request is high when the FIFO count is at or above the threshold, and low below it (absent other causes).
- R4: During a frame that has received fewer than 64 bytes, a FIFO count at or above a threshold below 64 does not raise the request.
- R5: After a frame accepted by the receiver ends, the request is high while the FIFO count is non-zero, regardless of the threshold. It stops when the FIFO empties.
- R6: With `low_lat_i` set, during a frame the request is high once more than 12 frame bytes have arrived and the FIFO is non-empty. At exactly 12 bytes it stays low.
- R7: A frame ending with fewer than 64 bytes counts as accepted if `runt_ok_i` is set and it has at least 8 bytes. Without `runt_ok_i`, or below 8 bytes, it does not raise the request.
- R8: A frame ending with `frame_stripped_i` high counts as accepted when `pad_strip_i` is set. With `pad_strip_i` clear it does not raise the request.
- R9: With `rx_en_i` low the request is low. A frame that began while the receiver was enabled still completes normally and is not counted as missed.
- R10: A frame that began while the receiver was disabled and would have been accepted increments `mpc_o` at its end. Frames that would have been rejected do not increment it.
- R11: `mpc_o` resets to 0, saturates at 255, and clears one edge after a `mpc_rd_i` strobe.
- R12: `mpc_roll_o` pulses for exactly one cycle when `mpc_o` first reaches 255.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| rx_en_i | input | 1 | Receiver enable |
| cfg_wr_i | input | 1 | Load threshold select |
| cfg_thr_i | input | 2 | Threshold select value |
| low_lat_i | input | 1 | Low-latency mode |
| runt_ok_i | input | 1 | Accept short frames of at least 8 bytes |
| pad_strip_i | input | 1 | Pad stripping enabled |
| fifo_count_i | input | CNT_W | Bytes currently held in the FIFO |
| frame_start_i | input | 1 | Strobe: frame begins |
| frame_end_i | input | 1 | Strobe: frame ends, length on frame_bytes_i |
| frame_bytes_i | input | LEN_W | Bytes of the current frame received so far |
| frame_stripped_i | input | 1 | Ending frame had its pad removed |
| mpc_rd_i | input | 1 | Read strobe, clears missed counter |
| req_o | output | 1 | Host data request (registered) |
| mpc_o | output | MPC_W | Missed frame count |
| mpc_roll_o | output | 1 | One-cycle pulse on reaching saturation |

## Verification
The bench builds the block with its default parameters: an 8-bit FIFO count, an 11-bit frame length, an 8-bit missed counter and a 64-byte minimum. The 8-bit counter lets the bench reach saturation and the rollover pulse with 255 disabled frames in a few hundred cycles. The 64-byte minimum makes the 16 and 32 thresholds fall well inside the hold-off window, so the first-assertion rule can be observed separately from the plain threshold.

// File: rtl/rxreq_pkg.sv
package rxreq_pkg;
  typedef enum logic [1:0] {
    THR_QUARTER = 2'b00,
    THR_HALF    = 2'b01,
    THR_FULL    = 2'b10,
    THR_FULL_B  = 2'b11
  } thr_sel_e;

  // Threshold in bytes, derived from the minimum frame size
  function automatic int unsigned thr_bytes(thr_sel_e s, int unsigned min_b);
    case (s)
      THR_QUARTER: return min_b / 4;
      THR_HALF:    return min_b / 2;
      default:     return min_b;
    endcase
  endfunction
endpackage

// File: rtl/rxreq_frame_track.sv
module rxreq_frame_track #(
  parameter int unsigned LEN_W     = 11,
  parameter int unsigned MIN_BYTES = 64,
  parameter int unsigned LL_BYTES  = 12,
  parameter int unsigned RUNT_MIN  = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             rx_en_i,
  input  logic             start_i,
  input  logic             end_i,
  input  logic [LEN_W-1:0] bytes_i,
  input  logic             runt_ok_i,
  input  logic             strip_en_i,
  input  logic             stripped_i,
  input  logic             fifo_empty_i,
  output logic             armed_o,
  output logic             tail_o,
  output logic             ll_hit_o,
  output logic             miss_o
);
  localparam logic [LEN_W-1:0] MIN_L  = LEN_W'(MIN_BYTES);
  localparam logic [LEN_W-1:0] LL_L   = LEN_W'(LL_BYTES);
  localparam logic [LEN_W-1:0] RUNT_L = LEN_W'(RUNT_MIN);

  logic live_q, fen_q, armed_q, tail_q;
  logic big_now, accept;

  assign big_now = bytes_i >= MIN_L;
  assign accept  = big_now | (runt_ok_i & (bytes_i >= RUNT_L)) | (strip_en_i & stripped_i);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      live_q  <= 1'b0;
      fen_q   <= 1'b1;
      armed_q <= 1'b0;
      tail_q  <= 1'b0;
    end else begin
      if (start_i) begin
        live_q  <= 1'b1;
        fen_q   <= rx_en_i;
        armed_q <= 1'b0;
      end else begin
        if (end_i) live_q <= 1'b0;
        if (live_q && big_now) armed_q <= 1'b1;
      end
      if (end_i && accept && fen_q) tail_q <= 1'b1;
      else if (fifo_empty_i)        tail_q <= 1'b0;
    end
  end

  assign armed_o  = armed_q | (live_q & big_now);
  assign tail_o   = tail_q;
  assign ll_hit_o = live_q & (bytes_i > LL_L);
  assign miss_o   = end_i & accept & ~fen_q;

  // R4: the sticky arm flag only rises after a minimum-size byte count
  assert_arm_after_min_R4: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(armed_q) |-> ($past(bytes_i) >= MIN_L));
  // R9: a frame begun while disabled never leaves a host-visible tail
  assert_no_tail_disabled_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (end_i && !fen_q && !tail_q) |=> !tail_q);
endmodule

// File: rtl/rxreq_miss_ctr.sv
module rxreq_miss_ctr #(
  parameter int unsigned MPC_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             inc_i,
  input  logic             rd_i,
  output logic [MPC_W-1:0] cnt_o,
  output logic             roll_o
);
  localparam logic [MPC_W-1:0] MAX_C = {MPC_W{1'b1}};

  logic [MPC_W-1:0] cnt_q;
  logic             roll_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q  <= '0;
      roll_q <= 1'b0;
    end else begin
      roll_q <= 1'b0;
      if (rd_i) begin
        cnt_q <= inc_i ? MPC_W'(1) : '0;
      end else if (inc_i && cnt_q != MAX_C) begin
        cnt_q  <= cnt_q + 1'b1;
        roll_q <= (cnt_q == MAX_C - 1'b1);
      end
    end
  end

  assign cnt_o  = cnt_q;
  assign roll_o = roll_q;

  // R11: saturated count holds until read
  assert_sat_hold_R11: assert property (@(posedge clk) disable iff (!rst_n)
    (cnt_q == MAX_C && !rd_i) |=> cnt_q == MAX_C);
  // R11: a read leaves at most the concurrent increment
  assert_read_clears_R11: assert property (@(posedge clk) disable iff (!rst_n)
    rd_i |=> cnt_q <= MPC_W'(1));
  // R12: rollover flag is a single-cycle pulse
  assert_roll_pulse_R12: assert property (@(posedge clk) disable iff (!rst_n)
    roll_q |=> !roll_q);
endmodule

// File: rtl/rxreq_gen.sv
module rxreq_gen #(
  parameter int unsigned CNT_W     = 8,
  parameter int unsigned LEN_W     = 11,
  parameter int unsigned MPC_W     = 8,
  parameter int unsigned MIN_BYTES = 64,
  parameter int unsigned LL_BYTES  = 12,
  parameter int unsigned RUNT_MIN  = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             rx_en_i,
  input  logic             cfg_wr_i,
  input  logic [1:0]       cfg_thr_i,
  input  logic             low_lat_i,
  input  logic             runt_ok_i,
  input  logic             pad_strip_i,
  input  logic [CNT_W-1:0] fifo_count_i,
  input  logic             frame_start_i,
  input  logic             frame_end_i,
  input  logic [LEN_W-1:0] frame_bytes_i,
  input  logic             frame_stripped_i,
  input  logic             mpc_rd_i,
  output logic             req_o,
  output logic [MPC_W-1:0] mpc_o,
  output logic             mpc_roll_o
);
  import rxreq_pkg::*;

  localparam int unsigned CW1 = CNT_W + 1;
  localparam logic [CW1-1:0] FULL_L = CW1'(MIN_BYTES);

  thr_sel_e       thr_q;
  logic [CW1-1:0] thr_val, fifo_ext;
  logic           armed, tail, ll_hit, miss, fifo_nz, req_d, req_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)        thr_q <= THR_FULL;
    else if (cfg_wr_i) thr_q <= thr_sel_e'(cfg_thr_i);
  end

  assign thr_val  = CW1'(thr_bytes(thr_q, MIN_BYTES));
  assign fifo_ext = {1'b0, fifo_count_i};
  assign fifo_nz  = |fifo_count_i;

  rxreq_frame_track #(
    .LEN_W(LEN_W), .MIN_BYTES(MIN_BYTES), .LL_BYTES(LL_BYTES), .RUNT_MIN(RUNT_MIN)
  ) u_track (
    .clk          (clk),
    .rst_n        (rst_n),
    .rx_en_i      (rx_en_i),
    .start_i      (frame_start_i),
    .end_i        (frame_end_i),
    .bytes_i      (frame_bytes_i),
    .runt_ok_i    (runt_ok_i),
    .strip_en_i   (pad_strip_i),
    .stripped_i   (frame_stripped_i),
    .fifo_empty_i (~fifo_nz),
    .armed_o      (armed),
    .tail_o       (tail),
    .ll_hit_o     (ll_hit),
    .miss_o       (miss)
  );

  rxreq_miss_ctr #(.MPC_W(MPC_W)) u_mpc (
    .clk    (clk),
    .rst_n  (rst_n),
    .inc_i  (miss),
    .rd_i   (mpc_rd_i),
    .cnt_o  (mpc_o),
    .roll_o (mpc_roll_o)
  );

  assign req_d = (fifo_ext >= FULL_L)
               | (armed & (fifo_ext >= thr_val))
               | (tail & fifo_nz)
               | (low_lat_i & ll_hit & fifo_nz);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) req_q <= 1'b0;
    else        req_q <= rx_en_i & req_d;
  end

  assign req_o = req_q;

  // R9: a disabled receiver never requests on the following cycle
  assert_req_off_disabled_R9: assert property (@(posedge clk) disable iff (!rst_n)
    !rx_en_i |=> !req_o);
  // R2: a FIFO holding the minimum block always requests when enabled
  assert_full_requests_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (rx_en_i && fifo_ext >= FULL_L) |=> req_o);
endmodule

// File: tb/rxreq_gen_test.sv
`timescale 1ns/1ps
module rxreq_gen_test;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic rx_en = 1'b1, cfg_wr = 1'b0, low_lat = 1'b0, runt_ok = 1'b0, pad_strip = 1'b0;
  logic [1:0]  cfg_thr = 2'b00;
  logic [7:0]  fifo_count = '0;
  logic        f_start = 1'b0, f_end = 1'b0, f_strip = 1'b0, mpc_rd = 1'b0;
  logic [10:0] f_bytes = '0;
  logic        req;
  logic [7:0]  mpc;
  logic        roll;

  int n_checks = 0, n_fail = 0;
  bit finished = 1'b0;

  int    q_sel[$];
  int    q_exp[$];
  string q_tag[$];
  event  chk_ev;

  always #2.5 clk = ~clk;

  rxreq_gen uut (
    .clk(clk), .rst_n(rst_n), .rx_en_i(rx_en), .cfg_wr_i(cfg_wr), .cfg_thr_i(cfg_thr),
    .low_lat_i(low_lat), .runt_ok_i(runt_ok), .pad_strip_i(pad_strip),
    .fifo_count_i(fifo_count), .frame_start_i(f_start), .frame_end_i(f_end),
    .frame_bytes_i(f_bytes), .frame_stripped_i(f_strip), .mpc_rd_i(mpc_rd),
    .req_o(req), .mpc_o(mpc), .mpc_roll_o(roll)
  );

  // Monitor: pops expectations and compares with the outputs
  initial begin
    forever begin
      @(chk_ev);
      while (q_sel.size() > 0) begin
        int sel, expv, act;
        string tag;
        sel = q_sel.pop_front(); expv = q_exp.pop_front(); tag = q_tag.pop_front();
        act = (sel == 0) ? int'(req) : (sel == 1) ? int'(mpc) : int'(roll);
        n_checks++;
        if (act != expv) begin
          n_fail++;
          $display("FAIL %s: actual %0d expected %0d", tag, act, expv);
        end
      end
    end
  end

  // Driver side: push an expectation (0 req, 1 count, 2 rollover)
  task automatic expect_val(int sel, int expv, string tag);
    q_sel.push_back(sel); q_exp.push_back(expv); q_tag.push_back(tag);
    ->chk_ev;
    #0;
  endtask

  task automatic settle();
    @(posedge clk); @(posedge clk); @(negedge clk);
  endtask

  task automatic pulse_start();
    f_start = 1'b1; @(negedge clk); f_start = 1'b0;
  endtask

  task automatic pulse_end();
    f_end = 1'b1; @(negedge clk); f_end = 1'b0;
  endtask

  task automatic set_thr(logic [1:0] v);
    cfg_thr = v; cfg_wr = 1'b1; @(negedge clk); cfg_wr = 1'b0;
  endtask

  task automatic frame(int len);
    pulse_start(); f_bytes = 11'(len); pulse_end();
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      n_checks++; n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    expect_val(0, 0, "R1 reset request");
    expect_val(1, 0, "R11 reset count");
    expect_val(2, 0, "R12 reset rollover");

    fifo_count = 8'd64; settle(); expect_val(0, 1, "R2 fifo at 64");
    fifo_count = 8'd40; settle(); expect_val(0, 0, "R2 fifo at 40");

    // Default threshold is 64: armed frame with 40 bytes queued stays low
    pulse_start(); f_bytes = 11'd70; settle();
    expect_val(0, 0, "R1 default threshold 64");
    f_bytes = 11'd70; pulse_end(); fifo_count = 8'd0; settle();

    set_thr(2'b00);
    pulse_start(); f_bytes = 11'd40; fifo_count = 8'd20; settle();
    expect_val(0, 0, "R4 hold-off before 64 bytes");
    f_bytes = 11'd64; settle(); expect_val(0, 1, "R3 armed at threshold 16");
    fifo_count = 8'd10; settle(); expect_val(0, 0, "R3 below threshold 16");
    set_thr(2'b01);
    fifo_count = 8'd20; settle(); expect_val(0, 0, "R1 threshold 32 not met");
    fifo_count = 8'd33; settle(); expect_val(0, 1, "R1 threshold 32 met");

    f_bytes = 11'd70; pulse_end(); fifo_count = 8'd5; settle();
    expect_val(0, 1, "R5 tail after frame end");
    fifo_count = 8'd0; settle(); expect_val(0, 0, "R5 tail ends on empty");

    frame(10); fifo_count = 8'd5; settle(); expect_val(0, 0, "R7 runt rejected");
    fifo_count = 8'd0; settle();
    runt_ok = 1'b1;
    frame(10); fifo_count = 8'd5; settle(); expect_val(0, 1, "R7 runt accepted");
    fifo_count = 8'd0; settle();
    frame(6); fifo_count = 8'd5; settle(); expect_val(0, 0, "R7 runt below 8");
    fifo_count = 8'd0; settle(); runt_ok = 1'b0;

    pad_strip = 1'b1; f_strip = 1'b1;
    frame(50); fifo_count = 8'd5; settle(); expect_val(0, 1, "R8 stripped frame");
    fifo_count = 8'd0; settle(); pad_strip = 1'b0;
    frame(50); fifo_count = 8'd5; settle(); expect_val(0, 0, "R8 stripping off");
    fifo_count = 8'd0; settle(); f_strip = 1'b0;

    low_lat = 1'b1;
    pulse_start(); f_bytes = 11'd12; fifo_count = 8'd12; settle();
    expect_val(0, 0, "R6 exactly 12 bytes");
    f_bytes = 11'd13; fifo_count = 8'd13; settle(); expect_val(0, 1, "R6 over 12 bytes");
    pulse_end(); settle(); expect_val(0, 0, "R6 only during frame");
    low_lat = 1'b0; fifo_count = 8'd0; settle();

    fifo_count = 8'd80; rx_en = 1'b0; settle(); expect_val(0, 0, "R9 disabled forces low");
    fifo_count = 8'd0; rx_en = 1'b1; settle();
    pulse_start(); rx_en = 1'b0; f_bytes = 11'd70; pulse_end();
    fifo_count = 8'd5; settle();
    expect_val(1, 0, "R9 in-flight frame not missed");
    expect_val(0, 0, "R9 request low while disabled");
    rx_en = 1'b1; settle(); expect_val(0, 1, "R9 in-flight frame completed");
    fifo_count = 8'd0; settle();

    rx_en = 1'b0;
    frame(70); settle(); expect_val(1, 1, "R10 missed frame counted");
    frame(10); settle(); expect_val(1, 1, "R10 rejected frame not counted");
    rx_en = 1'b1;
    frame(70); settle(); expect_val(1, 1, "R10 enabled frame not counted");
    fifo_count = 8'd0; settle();
    mpc_rd = 1'b1; @(negedge clk); mpc_rd = 1'b0;
    expect_val(1, 0, "R11 cleared on read");

    rx_en = 1'b0;
    for (int i = 0; i < 254; i++) frame(70);
    expect_val(2, 0, "R12 no pulse before saturation");
    frame(70);
    expect_val(1, 255, "R11 reached 255");
    expect_val(2, 1, "R12 rollover pulse");
    @(negedge clk); expect_val(2, 0, "R12 pulse one cycle");
    frame(70); expect_val(1, 255, "R11 saturates");
    expect_val(2, 0, "R12 no repeat pulse");
    mpc_rd = 1'b1; @(negedge clk); mpc_rd = 1'b0;
    expect_val(1, 0, "R11 read clears saturated count");

    finished = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
    $finish;
  end
endmodule